// File: doc/BRIEF.md
# Prescaled Down-Counting Reload Timer

This block is a 32-bit timer on a simple register bus. The counter runs downward at a tick rate set by a static prescaler exponent. When the count runs out, the block records a pending event and, if the event is not masked, raises a level interrupt. Software sets a reload value, picks single-shot or auto-reload operation, and starts the timer. Starting the timer copies the reload value into the live count. While the timer is stopped, software may also write the live count directly.

In single-shot operation the count stops at zero and the hardware drops its own run bit. In auto-reload operation the count is refilled from the reload value and keeps running. The pending event remains set until software writes a one to a dedicated clear location.

Top module: `countdown_timer`

## Requirements
- R1: After reset, control reads 0x2 (stopped, masked, single-shot), reload and count read 0xFFFFFFFF, status reads 0, and irq_o is low.
- R2: The registers sit at byte addresses 0x00 (control: bit 0 run, bit 1 interrupt mask with 1 meaning masked, bit 2 auto-reload), 0x04 (reload value), 0x08 (live count), 0x0C (status, bit 0 pending) and 0x10 (clear). Read data appears on rdata_o in the cycle after rd_en_i and is zero in every other cycle. Unused bits, the clear location and unmapped addresses read zero.
- R3: A control write that takes the run bit from 0 to 1 copies the reload value into the live count.
- R4: While running, the count drops by one on each tick. A tick occurs on every 2^PRESC_EXP-th cycle of running. The prescaler restarts whenever the timer is stopped, and a stopped count does not change.
- R5: In single-shot mode, a tick that finds the count at 1 or 0 sets pending, leaves the count at 0 and clears the run bit.
- R6: In auto-reload mode, a tick that finds the count at 1 or 0 sets pending, refills the count from the reload value and keeps the timer running.
- R7: irq_o is high exactly when pending is set and the mask bit is clear.
- R8: A write with bit 0 set to address 0x10 clears pending, and a write with bit 0 clear has no effect. When a pending set falls in the same cycle as a clear, the set wins.
- R9: A write to the live count takes effect only while the timer is stopped. While the timer is running, such a write is ignored.
- R10: A reload value of 0 produces a zero event on the first tick after the timer starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 5 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after rd_en_i |
| irq_o | output | 1 | Level interrupt |

## Verification
The count running out and a software clear of pending can land on the same clock edge. The bench provokes this by holding a clear write on the bus for thirty consecutive cycles while an auto-reload timer with a short period expires inside that window. The outcome is judged cycle by cycle against a behavioural model, which expects a single-cycle interrupt pulse on every expiry because the set wins and the still-present clear removes pending one edge later. A second coincidence, a software control write on the edge where a single-shot expiry drops the run bit, is resolved in favour of the software value. The model encodes the same rule.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_LOAD  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_COUNT = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 5'h10;

  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_DIS_BIT = 1;
  localparam int unsigned CTRL_PER_BIT = 2;
  localparam int unsigned CTRL_W       = 3;

  typedef struct packed {
    logic periodic;
    logic irq_dis;
    logic en;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{periodic: 1'b0, irq_dis: 1'b1, en: 1'b0};
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned PRESC_EXP = 0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  generate
    if (PRESC_EXP == 0) begin : g_direct
      logic unused_w;
      assign unused_w = clk_i ^ rst_ni;
      assign tick_o   = run_i;
    end else begin : g_div
      logic [PRESC_EXP-1:0] div_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     div_q <= '0;
        else if (!run_i) div_q <= '0;
        else             div_q <= div_q + 1'b1;
      end
      assign tick_o = run_i & (&div_q);
    end
  endgenerate
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic             periodic_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic             sw_wr_i,
  input  logic [CNT_W-1:0] sw_data_i,
  output logic [CNT_W-1:0] count_o,
  output logic             zero_evt_o
);
  logic [CNT_W-1:0] count_q;
  logic             near_zero;

  // count of 1 or 0 means this tick reaches zero
  assign near_zero  = (count_q[CNT_W-1:1] == '0);
  assign zero_evt_o = tick_i & near_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        count_q <= '1;
    else if (start_i)   count_q <= load_i;
    else if (sw_wr_i)   count_q <= sw_data_i;
    else if (tick_i) begin
      if (near_zero)    count_q <= periodic_i ? load_i : '0;
      else              count_q <= count_q - 1'b1;
    end
  end

  assign count_o = count_q;
endmodule

// File: rtl/tmr_regfile.sv
module tmr_regfile
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              zero_evt_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  load_o,
  output logic              start_o,
  output logic              cnt_wr_o,
  output logic              pend_o,
  output logic [CNT_W-1:0]  rdata_o
);
  localparam int unsigned PAD_CTRL = CNT_W - CTRL_W;

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] load_q;
  logic             pend_q;
  logic [CNT_W-1:0] rdata_q;
  logic             wr_ctrl, wr_load, wr_clr;
  ctrl_t            ctrl_wr;

  assign wr_ctrl = wr_en_i && (addr_i == OFS_CTRL);
  assign wr_load = wr_en_i && (addr_i == OFS_LOAD);
  assign wr_clr  = wr_en_i && (addr_i == OFS_CLR) && wdata_i[0];

  assign ctrl_wr.en       = wdata_i[CTRL_EN_BIT];
  assign ctrl_wr.irq_dis  = wdata_i[CTRL_DIS_BIT];
  assign ctrl_wr.periodic = wdata_i[CTRL_PER_BIT];

  assign start_o  = wr_ctrl && ctrl_wr.en && !ctrl_q.en;
  assign cnt_wr_o = wr_en_i && (addr_i == OFS_COUNT) && !ctrl_q.en;

  // software control write wins over the hardware stop
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            ctrl_q <= CTRL_RST;
    else if (wr_ctrl)                       ctrl_q <= ctrl_wr;
    else if (zero_evt_i && !ctrl_q.periodic) ctrl_q.en <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      load_q <= '1;
    else if (wr_load) load_q <= wdata_i;
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pend_q <= 1'b0;
    else if (zero_evt_i) pend_q <= 1'b1;
    else if (wr_clr)     pend_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (rd_en_i) begin
      unique case (addr_i)
        OFS_CTRL:  rdata_q <= {{PAD_CTRL{1'b0}}, ctrl_q};
        OFS_LOAD:  rdata_q <= load_q;
        OFS_COUNT: rdata_q <= count_i;
        OFS_STAT:  rdata_q <= {{(CNT_W-1){1'b0}}, pend_q};
        default:   rdata_q <= '0;
      endcase
    end else begin
      rdata_q <= '0;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign load_o  = load_q;
  assign pend_o  = pend_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/countdown_timer.sv
module countdown_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned PRESC_EXP = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic              irq_o
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] load_val, count_val;
  logic             start, cnt_wr, pend, tick, zero_evt;
  logic             en_w, dis_w, per_w;

  assign en_w  = ctrl.en;
  assign dis_w = ctrl.irq_dis;
  assign per_w = ctrl.periodic;

  tmr_regfile #(.CNT_W(CNT_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .rd_en_i    (rd_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .count_i    (count_val),
    .zero_evt_i (zero_evt),
    .ctrl_o     (ctrl),
    .load_o     (load_val),
    .start_o    (start),
    .cnt_wr_o   (cnt_wr),
    .pend_o     (pend),
    .rdata_o    (rdata_o)
  );

  tmr_prescaler #(.PRESC_EXP(PRESC_EXP)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (en_w),
    .tick_o (tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .tick_i     (tick),
    .periodic_i (per_w),
    .load_i     (load_val),
    .sw_wr_i    (cnt_wr),
    .sw_data_i  (wdata_i),
    .count_o    (count_val),
    .zero_evt_o (zero_evt)
  );

  assign irq_o = pend & ~dis_w;
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [4:0]       addr_i,
  input logic             irq_o,
  input logic             pend,
  input logic             en,
  input logic             per,
  input logic             tick,
  input logic             zero_evt,
  input logic             start,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] load
);
  // R7
  irq_needs_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> pend);

  // R8
  evt_sets_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_evt |=> pend);

  // R5
  oneshot_stops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_evt && !per && !(wr_en_i && addr_i == 5'h00)) |=> (!en && count == '0));

  // R6
  periodic_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_evt && per && !wr_en_i) |=> (en && count == $past(load)));

  // R3
  start_loads_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> count == $past(load));

  // R4
  tick_decr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !zero_evt) |=> count == $past(count) - 1'b1);

  // R4
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !wr_en_i) |=> $stable(count));
endmodule

bind countdown_timer tmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .irq_o    (irq_o),
  .pend     (pend),
  .en       (en_w),
  .per      (per_w),
  .tick     (tick),
  .zero_evt (zero_evt),
  .start    (start),
  .count    (count_val),
  .load     (load_val)
);

// File: tb/sim_countdown_timer.sv
`timescale 1ns/1ps
module sim_countdown_timer;
  localparam int unsigned P   = 2;
  localparam int unsigned DIV = 1 << P;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  always #2 clk = ~clk;

  countdown_timer #(.CNT_W(32), .PRESC_EXP(P)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  int    n_chk = 0, n_fail = 0;
  bit    done = 1'b0;
  string tag = "R1";

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h @%0t", t, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit          m_en, m_dis, m_per, m_pend, rd_chk;
  logic [31:0] m_load, m_cnt, exp_rd;
  int          m_pre;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_dis = 1; m_per = 0; m_pend = 0;
      m_load = 32'hFFFF_FFFF; m_cnt = 32'hFFFF_FFFF; m_pre = 0;
      exp_rd = 0; rd_chk = 0;
    end else begin
      bit tk, ev, n_en;
      logic [31:0] n_cnt;
      tk = m_en && (m_pre == DIV - 1);
      ev = tk && (m_cnt <= 1);
      rd_chk = rd_en;
      exp_rd = 0;
      if (rd_en) begin
        case (addr)
          5'h00: exp_rd = {29'd0, m_per, m_dis, m_en};
          5'h04: exp_rd = m_load;
          5'h08: exp_rd = m_cnt;
          5'h0C: exp_rd = {31'd0, m_pend};
          default: exp_rd = 0;
        endcase
      end
      n_cnt = m_cnt;
      if (wr_en && addr == 5'h00 && wdata[0] && !m_en) n_cnt = m_load;
      else if (wr_en && addr == 5'h08 && !m_en)       n_cnt = wdata;
      else if (tk) n_cnt = ev ? (m_per ? m_load : 0) : m_cnt - 1;
      m_pre = m_en ? (m_pre + 1) % DIV : 0;
      n_en = m_en;
      if (wr_en && addr == 5'h00) begin
        n_en = wdata[0]; m_dis = wdata[1]; m_per = wdata[2];
      end else if (ev && !m_per) n_en = 0;
      m_en = n_en;
      m_cnt = n_cnt;
      if (wr_en && addr == 5'h04) m_load = wdata;
      if (ev) m_pend = 1;
      else if (wr_en && addr == 5'h10 && wdata[0]) m_pend = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R7 irq", {31'd0, irq}, {31'd0, m_pend && !m_dis});
      if (rd_chk) chk({tag, " rdata"}, rdata, exp_rd);
      else        chk("R2 idle rdata", rdata, 32'd0);
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; addr = '0; wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; addr = '0; v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    int irq_hi;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1 reset values
    tag = "R1";
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rd(5'h00, v); chk("R1 ctrl", v, 32'h2);
    rd(5'h04, v); chk("R1 load", v, 32'hFFFF_FFFF);
    rd(5'h08, v); chk("R1 count", v, 32'hFFFF_FFFF);
    rd(5'h0C, v); chk("R1 status", v, 32'd0);

    // R2 unmapped and clear location read zero
    tag = "R2";
    rd(5'h10, v); chk("R2 clr reads 0", v, 32'd0);
    rd(5'h14, v); chk("R2 unmapped", v, 32'd0);
    wr(5'h00, 32'hFFFF_FFF8);
    rd(5'h00, v); chk("R2 ctrl unused bits", v, 32'd0);

    // R9 count write while stopped
    tag = "R9";
    wr(5'h08, 32'h0000_1234);
    rd(5'h08, v); chk("R9 stopped write", v, 32'h0000_1234);

    // R3/R5 one-shot, load 5, unmasked
    tag = "R5";
    wr(5'h04, 32'd5);
    wr(5'h00, 32'h1);
    rd(5'h08, v);
    chk("R3 start copies load", {31'd0, (v <= 5)}, 32'd1);
    idle(40);
    rd(5'h08, v); chk("R5 count held 0", v, 32'd0);
    rd(5'h00, v); chk("R5 run bit cleared", v, 32'd0);
    rd(5'h0C, v); chk("R5 pending", v, 32'd1);
    chk("R7 irq high", {31'd0, irq}, 32'd1);

    // R8 clear: bit0=0 ignored, bit0=1 clears
    tag = "R8";
    wr(5'h10, 32'h2);
    rd(5'h0C, v); chk("R8 zero write ignored", v, 32'd1);
    wr(5'h10, 32'h1);
    rd(5'h0C, v); chk("R8 clear", v, 32'd0);

    // R7 masked pending
    tag = "R7";
    wr(5'h04, 32'd2);
    wr(5'h00, 32'h3);
    idle(20);
    rd(5'h0C, v); chk("R7 pend while masked", v, 32'd1);
    chk("R7 irq masked", {31'd0, irq}, 32'd0);
    wr(5'h10, 32'h1);

    // R4 decrement rate: load 100, run, read count later
    tag = "R4";
    wr(5'h04, 32'd100);
    wr(5'h00, 32'h1);
    idle(DIV * 10);
    rd(5'h08, v);
    chk("R4 decremented", {31'd0, (v < 100 && v > 80)}, 32'd1);
    // R9 write ignored while running
    tag = "R9";
    wr(5'h08, 32'd5);
    rd(5'h08, v); chk("R9 running write ignored", {31'd0, (v > 50)}, 32'd1);
    wr(5'h00, 32'h0);
    tag = "R4";
    rd(5'h08, v);
    idle(30);
    begin
      logic [31:0] v2;
      rd(5'h08, v2); chk("R4 stopped holds", v2, v);
    end

    // R6 periodic, load 3, unmasked
    tag = "R6";
    wr(5'h10, 32'h1);
    wr(5'h04, 32'd3);
    wr(5'h00, 32'h5);
    idle(60);
    rd(5'h00, v); chk("R6 still running", v, 32'h5);
    rd(5'h0C, v); chk("R6 pending", v, 32'd1);

    // R8 set vs clear in the same cycle: hold clear across expiries
    tag = "R8";
    irq_hi = 0;
    @(negedge clk); wr_en = 1; addr = 5'h10; wdata = 32'h1;
    repeat (30) begin
      @(negedge clk);
      if (irq) irq_hi++;
    end
    wr_en = 0; addr = '0; wdata = '0;
    chk("R8 set wins pulses", {31'd0, (irq_hi >= 2)}, 32'd1);
    wr(5'h00, 32'h0);
    wr(5'h10, 32'h1);

    // R10 load zero
    tag = "R10";
    wr(5'h04, 32'd0);
    wr(5'h00, 32'h1);
    idle(DIV + 2);
    rd(5'h0C, v); chk("R10 zero event", v, 32'd1);
    rd(5'h08, v); chk("R10 count", v, 32'd0);
    rd(5'h00, v); chk("R10 stopped", v, 32'd0);

    idle(4);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule